// File: doc/BRIEF.md
# Dual 8-bit compare-match timer

This block holds two independent 8-bit up-counters, Timer A and Timer B, which run off the system clock `clk`. Each timer has a clock-select field, a compare value, a run/pause bit and a self-clearing start/clear bit. Both timers sit on a small register bus. On each enabled count tick, a counter whose value equals its compare value returns to zero, sets its interrupt flag and inverts its match-toggle output. Each flag stays set until its acknowledge input clears it.

Timer A picks one of seven power-of-two divisions of `clk` or the rising edges of an external pin. The pin is synchronized and edge-detected, so all counting stays in the `clk` domain. Timer B picks a division from 1 to 16384. Each timer has its own divider, and a start/clear write resets that divider together with the counter. Software programs the compare value and the clock code, then writes the control register with both the run bit and the start/clear bit set.

Top module: `dual_match_timer`

## Requirements
- R1: After reset both control registers read 0x00, both compare registers read 0xFF, both counters read 0, and `irq_a`, `irq_b`, `tog_a` and `tog_b` are 0.
- R2: The bus address map is 0 Timer A control, 1 Timer B control, 2 Timer A compare, 3 Timer B compare, 4 Timer A counter (read only) and 5 Timer B counter (read only). Every other address reads 0. Timer A control has bit7 enable, bit5 mode, bits4:2 clock code, bit1 run and bit0 start/clear. Timer B control has bit7 cascade, bit6 mode, bit5 run, bit4 start/clear and bits3:0 clock code. Start/clear bits always read 0, and Timer A control bit6 reads 0.
- R3: With Timer B clock code n, where n is 0 to 14, Timer B advances once every 2^n `clk` cycles. Its first advance comes 2^n edges after the start/clear write edge.
- R4: Timer A clock codes 0 to 6 select divisions of 2, 4, 8, 32, 128, 512 and 2048, with the same timing as R3.
- R5: With Timer A clock code 7, Timer A advances once for each rising edge of `ext_a`.
- R6: A count tick that finds the counter equal to its compare value loads the counter with 0, sets that timer's interrupt flag and inverts its toggle output.
- R7: A timer's acknowledge input clears its interrupt flag. If a flag set and an acknowledge fall on the same edge, the flag stays set.
- R8: A control write with the start/clear bit at 1 zeroes that timer's counter and divider phase.
- R9: A counter holds its value while its run bit is 0. Timer A also holds while its enable bit is 0.
- R10: Timer B clock code 15 is reserved, and Timer B does not count while it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that every divider uses |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_a | input | 1 | External count clock for Timer A, asynchronous |
| ack_a | input | 1 | Interrupt acknowledge for Timer A |
| ack_b | input | 1 | Interrupt acknowledge for Timer B |
| irq_a | output | 1 | Timer A interrupt flag |
| irq_b | output | 1 | Timer B interrupt flag |
| tog_a | output | 1 | Timer A match-toggle output |
| tog_b | output | 1 | Timer B match-toggle output |

## Verification
The hardest case to reach from the ports is a flag set and an acknowledge landing on the same edge. A compare match occurs only once per full counter period. The bench sets Timer B's compare value to 0 at division 1, so every clock edge produces a match, and then holds the acknowledge high for several edges. The slowest division of 16384 also needs care: the bench checks the counter one edge before and one edge after the first tick, which catches an off-by-one error in the divider mask.

// File: rtl/dmt_pkg.sv
// Shared constants for the dual compare-match timer: register addresses,
// control bit positions and the Timer A clock-code to shift mapping.
package dmt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL_A = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL_B = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMP_A  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMP_B  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT_A  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT_B  = 3'd5;

    // Timer A control bit positions
    localparam int A_EN  = 7;
    localparam int A_RUN = 1;
    localparam int A_CLR = 0;
    // Timer B control bit positions
    localparam int B_RUN = 5;
    localparam int B_CLR = 4;

    // Writable bits (start/clear bits are never stored)
    localparam logic [DATA_W-1:0] A_KEEP = 8'hBE;
    localparam logic [DATA_W-1:0] B_KEEP = 8'hEF;

    localparam logic [2:0] A_CODE_EXT = 3'd7;
    localparam logic [3:0] B_CODE_RSV = 4'hF;

    // Timer A clock code to log2 of the division
    function automatic logic [3:0] a_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd3;
            3'd3:    return 4'd5;
            3'd4:    return 4'd7;
            3'd5:    return 4'd9;
            default: return 4'd11;
        endcase
    endfunction
endpackage

// File: rtl/dmt_prescaler.sv
// Free-running divider with a synchronous phase clear.
// Emits a one-cycle tick once every 2^shift cycles, first one 2^shift
// edges after the clear edge. Assumes shift <= DIV_W.
module dmt_prescaler #(
    parameter int DIV_W = 14,
    parameter int SH_W  = $clog2(DIV_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [SH_W-1:0] shift,
    output logic            tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Divider phase: restarts from zero on reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Tick when all low 'shift' bits are ones
    always_comb begin
        mask = (DIV_W'(1) << shift) - DIV_W'(1);
        tick = &(div_q | ~mask);
    end
endmodule

// File: rtl/dmt_edge_sync.sv
// Brings an asynchronous pin into the clk domain with two flops and
// produces a one-cycle pulse on each rising edge. Assumes the pin stays
// high and stays low for at least two clk cycles each.
module dmt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [2:0] sh_q;

    // Synchronizer plus history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], pin};
    end

    // Rising-edge detect on the synchronized level
    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/dmt_core.sv
// One compare-match counter. On a tick it either steps up or, when equal
// to the limit, wraps to zero, sets the flag and flips the toggle.
// The flag is cleared by ack unless a match lands in the same cycle.
module dmt_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    input  logic         ack,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         tog
);
    logic hit;
    logic match;

    // Match decode for this cycle
    assign hit   = (cnt == limit);
    assign match = tick & hit & ~clr;

    // Counter: clear, wrap on match, or step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= hit ? '0 : cnt + 1'b1;
    end

    // Interrupt flag and toggle output; set beats ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            tog  <= 1'b0;
        end else begin
            if (match)    flag <= 1'b1;
            else if (ack) flag <= 1'b0;
            if (match)    tog  <= ~tog;
        end
    end
endmodule

// File: rtl/dual_match_timer.sv
// Two 8-bit compare-match timers on a small register bus. Timer A uses
// an 11-bit divider or the synchronized external pin; Timer B uses a
// 14-bit divider. All logic runs on clk. Reads are combinational.
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int A_DIV_W = 11,
    parameter int B_DIV_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_a,
    input  logic              ack_a,
    input  logic              ack_b,
    output logic              irq_a,
    output logic              irq_b,
    output logic              tog_a,
    output logic              tog_b
);
    localparam int A_SH_W = $clog2(A_DIV_W + 1);
    localparam int B_SH_W = $clog2(B_DIV_W + 1);

    logic [DATA_W-1:0] ctrl_a_q, ctrl_b_q;
    logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, cnt_a, cnt_b;
    logic              wr_ca, wr_cb, clr_a, clr_b;
    logic              pre_a, pre_b, ext_rise, tick_a, tick_b;
    logic [2:0]        sel_a;
    logic [3:0]        sel_b;

    // Write decode and start/clear strobes
    assign wr_ca = bus_wr && (bus_addr == ADR_CTRL_A);
    assign wr_cb = bus_wr && (bus_addr == ADR_CTRL_B);
    assign clr_a = wr_ca && bus_wdata[A_CLR];
    assign clr_b = wr_cb && bus_wdata[B_CLR];
    assign sel_a = ctrl_a_q[4:2];
    assign sel_b = ctrl_b_q[3:0];

    // Register file writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
            cmp_a_q  <= '1;
            cmp_b_q  <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_CTRL_A: ctrl_a_q <= bus_wdata & A_KEEP;
                ADR_CTRL_B: ctrl_b_q <= bus_wdata & B_KEEP;
                ADR_CMP_A:  cmp_a_q  <= bus_wdata[CNT_W-1:0];
                ADR_CMP_B:  cmp_b_q  <= bus_wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            ADR_CTRL_A: bus_rdata = ctrl_a_q;
            ADR_CTRL_B: bus_rdata = ctrl_b_q;
            ADR_CMP_A:  bus_rdata = DATA_W'(cmp_a_q);
            ADR_CMP_B:  bus_rdata = DATA_W'(cmp_b_q);
            ADR_CNT_A:  bus_rdata = DATA_W'(cnt_a);
            ADR_CNT_B:  bus_rdata = DATA_W'(cnt_b);
            default:    bus_rdata = '0;
        endcase
    end

    dmt_prescaler #(.DIV_W(A_DIV_W)) u_pre_a (
        .clk(clk), .rst_n(rst_n), .clr(clr_a),
        .shift(A_SH_W'(a_shift(sel_a))), .tick(pre_a)
    );

    dmt_prescaler #(.DIV_W(B_DIV_W)) u_pre_b (
        .clk(clk), .rst_n(rst_n), .clr(clr_b),
        .shift(B_SH_W'(sel_b)), .tick(pre_b)
    );

    dmt_edge_sync u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_a), .rise(ext_rise)
    );

    // Count-enable selection per timer
    assign tick_a = ctrl_a_q[A_EN] & ctrl_a_q[A_RUN]
                  & ((sel_a == A_CODE_EXT) ? ext_rise : pre_a);
    assign tick_b = ctrl_b_q[B_RUN] & (sel_b != B_CODE_RSV) & pre_b;

    dmt_core #(.W(CNT_W)) u_core_a (
        .clk(clk), .rst_n(rst_n), .clr(clr_a), .tick(tick_a),
        .limit(cmp_a_q), .ack(ack_a), .cnt(cnt_a), .flag(irq_a), .tog(tog_a)
    );

    dmt_core #(.W(CNT_W)) u_core_b (
        .clk(clk), .rst_n(rst_n), .clr(clr_b), .tick(tick_b),
        .limit(cmp_b_q), .ack(ack_b), .cnt(cnt_b), .flag(irq_b), .tog(tog_b)
    );
endmodule

// File: rtl/dmt_checker.sv
// Temporal checks for dual_match_timer, attached with bind.
module dmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       ack_a,
    input logic       ack_b,
    input logic       irq_a,
    input logic       irq_b,
    input logic       tog_a,
    input logic       tog_b,
    input logic [7:0] ctrl_a,
    input logic [7:0] ctrl_b,
    input logic [7:0] cnt_a,
    input logic [7:0] cnt_b
);
    logic cw_a, cw_b;
    assign cw_a = bus_wr && bus_addr == 3'd0 && bus_wdata[0];
    assign cw_b = bus_wr && bus_addr == 3'd1 && bus_wdata[4];

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cw_b |=> cnt_b == 8'd0);
    assert_hold_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_a[7] && ctrl_a[1]) && !cw_a) |=> $stable(cnt_a));
    assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_b[3:0] == 4'hF && !cw_b) |=> $stable(cnt_b));
    assert_ack_only_clears_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_a) |-> $past(ack_a));
    assert_ack_only_clears_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_b) |-> $past(ack_b));
    assert_toggle_with_flag_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_a != $past(tog_a)) |-> irq_a);
    assert_toggle_with_flag_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_b != $past(tog_b)) |-> irq_b);
endmodule

bind dual_match_timer dmt_checker chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ack_a(ack_a), .ack_b(ack_b), .irq_a(irq_a),
    .irq_b(irq_b), .tog_a(tog_a), .tog_b(tog_b), .ctrl_a(ctrl_a_q),
    .ctrl_b(ctrl_b_q), .cnt_a(cnt_a), .cnt_b(cnt_b)
);

// File: tb/dual_match_timer_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module dual_match_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_a = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
    logic       irq_a, irq_b, tog_a, tog_b;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    dual_match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_a(ext_a),
        .ack_a(ack_a), .ack_b(ack_b), .irq_a(irq_a), .irq_b(irq_b),
        .tog_a(tog_a), .tog_b(tog_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack(input bit b);
        @(negedge clk);
        if (b) ack_b = 1'b1; else ack_a = 1'b1;
        @(negedge clk);
        ack_a = 1'b0; ack_b = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); chk("R1 ctrlA", v, 8'h00);
        rd(3'd1, v); chk("R1 ctrlB", v, 8'h00);
        rd(3'd2, v); chk("R1 cmpA", v, 8'hFF);
        rd(3'd3, v); chk("R1 cmpB", v, 8'hFF);
        rd(3'd4, v); chk("R1 cntA", v, 8'h00);
        rd(3'd5, v); chk("R1 cntB", v, 8'h00);
        chk("R1 irq/tog", {4'h0, irq_a, irq_b, tog_a, tog_b}, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(3'd0, 8'hFE); rd(3'd0, v); chk("R2 ctrlA bit6/bit0 read 0", v, 8'hBE);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h5A); rd(3'd2, v); chk("R2 cmpA readback", v, 8'h5A);
        rd(3'd6, v); chk("R2 unmapped reads 0", v, 8'h00);
    endtask

    task automatic t_b_div1;
        logic [7:0] v;
        wr(3'd3, 8'd200);
        wr(3'd1, 8'h30);
        rd(3'd1, v); chk("R2 ctrlB clear bit self-clears", v, 8'h20);
        edges(10);
        rd(3'd5, v); chk("R3 B div1 count", v, 8'd10);
    endtask

    task automatic t_b_match;
        logic [7:0] v, held;
        wr(3'd3, 8'd4);
        wr(3'd1, 8'h30);
        edges(4);
        rd(3'd5, v); chk("R6 B before match", v, 8'd4);
        chk("R6 B no flag yet", {7'd0, irq_b}, 8'd0);
        edges(1);
        rd(3'd5, v); chk("R6 B wrapped", v, 8'd0);
        chk("R6 B flag+toggle", {6'd0, irq_b, tog_b}, 8'd3);
        wr(3'd1, 8'h00);
        rd(3'd5, held);
        edges(20);
        rd(3'd5, v); chk("R9 B paused holds", v, held);
        pulse_ack(1'b1);
        chk("R7 B ack clears", {7'd0, irq_b}, 8'd0);
    endtask

    task automatic t_b_priority;
        wr(3'd3, 8'd0);
        wr(3'd1, 8'h30);
        edges(3);
        chk("R6 B flag set at cmp 0", {7'd0, irq_b}, 8'd1);
        @(negedge clk) ack_b = 1'b1;
        edges(3);
        chk("R7 set beats ack", {7'd0, irq_b}, 8'd1);
        ack_b = 1'b0;
        wr(3'd1, 8'h00);
        edges(1);
        pulse_ack(1'b1);
        chk("R7 B ack after stop", {7'd0, irq_b}, 8'd0);
    endtask

    task automatic t_b_reserved;
        logic [7:0] v;
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'h3F);
        edges(50);
        rd(3'd5, v); chk("R10 B code 15 no count", v, 8'd0);
    endtask

    task automatic t_b_slow;
        logic [7:0] v;
        wr(3'd1, 8'h3E);
        rd(3'd5, v); chk("R8 B cleared by start", v, 8'd0);
        edges(16383);
        rd(3'd5, v); chk("R3 B div16384 one early", v, 8'd0);
        edges(1);
        rd(3'd5, v); chk("R3 B div16384 first tick", v, 8'd1);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_a_div;
        logic [7:0] v;
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h8B);
        rd(3'd0, v); chk("R2 ctrlA readback", v, 8'h8A);
        edges(23);
        rd(3'd4, v); chk("R4 A div8 23 edges", v, 8'd2);
        edges(1);
        rd(3'd4, v); chk("R4 A div8 24 edges", v, 8'd3);
        wr(3'd0, 8'h9B);
        rd(3'd4, v); chk("R8 A cleared by start", v, 8'd0);
        edges(4095);
        rd(3'd4, v); chk("R4 A div2048 early", v, 8'd1);
        edges(1);
        rd(3'd4, v); chk("R4 A div2048 second tick", v, 8'd2);
        wr(3'd0, 8'h0B);
        edges(40);
        rd(3'd4, v); chk("R9 A enable off holds", v, 8'd0);
    endtask

    task automatic t_a_match;
        logic [7:0] v;
        wr(3'd2, 8'd2);
        wr(3'd0, 8'h83);
        edges(6);
        rd(3'd4, v); chk("R6 A wrapped", v, 8'd0);
        chk("R6 A flag+toggle", {6'd0, irq_a, tog_a}, 8'd3);
        wr(3'd0, 8'h80);
        pulse_ack(1'b0);
        chk("R7 A ack clears", {7'd0, irq_a}, 8'd0);
    endtask

    task automatic t_a_ext;
        logic [7:0] v;
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h9F);
        for (int i = 0; i < 5; i++) begin
            repeat (3) @(negedge clk);
            ext_a = 1'b1;
            repeat (3) @(negedge clk);
            ext_a = 1'b0;
        end
        edges(5);
        rd(3'd4, v); chk("R5 A external edges", v, 8'd5);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_b_div1();
        t_b_match();
        t_b_priority();
        t_b_reserved();
        t_b_slow();
        t_a_div();
        t_a_match();
        t_a_ext();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule